// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block runs once each time the external reset is released. On the first clock edge after reset is released it samples a set of configuration pins. The pins decide whether internal or external memory answers at address 0, what kind of external memory that is, and which boot process prepares address 0. The block then keeps the CPU in internal reset until that process is complete. The rest of the device already runs during this time.

Three flows are provided:

- **Direct execution.** The CPU is released at once. If external SDRAM sits at address 0, release waits for the SDRAM controller to report that initialization is finished.
- **ROM boot.** A single copy request goes to a DMA engine, with a source address and length fixed by parameters. The CPU stays held until the engine signals completion.
- **Host boot.** An external host fills memory and then writes a completion strobe. The CPU is released one cycle after that strobe is seen.

The block has three outputs for the rest of the chip: the CPU run signal, the address-0 map select and a status code.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst` is high, `cpu_run`=0, `dma_req`=0, `map_ext`=0 and `status`=0 (idle).
- R2: `cfg_map_ext`, `cfg_mem_type` and `cfg_boot` are captured at the first rising edge with `rst` low. Later changes have no effect on `map_ext`, `status` or `cpu_run` until the next reset.
- R3: With `cfg_boot`=00 (direct), the CPU is released at the capture edge when address 0 is not SDRAM. Address 0 is not SDRAM when `cfg_map_ext`=0, whatever the type, or when `cfg_map_ext`=1 with `cfg_mem_type`!=01. After that edge, `cpu_run`=1, `status`=4 (running) and `map_ext` equals the captured pin.
- R4: With `cfg_boot`=00, `cfg_map_ext`=1 and `cfg_mem_type`=01 (SDRAM), `status`=1 and `cpu_run`=0 until `sdram_init_done` is sampled high. The edge that samples it sets `cpu_run`=1 and `status`=4.
- R5: With `cfg_boot`=01 (ROM), the capture edge sets `status`=2 and raises `dma_req` for exactly one cycle. `dma_src` and `dma_len` then carry the parameter values. The CPU stays held until `dma_done` is sampled high, and that edge releases it. `host_done` has no effect in this flow.
- R6: With `cfg_boot`=10 (host), `status`=3 and the CPU is held. If `host_done` is sampled high at edge N, `cpu_run` stays 0 after N and becomes 1 (`status`=4) after edge N+1. `dma_done` has no effect in this flow.
- R7: `cfg_boot`=11 behaves exactly as direct execution.
- R8: Once `cpu_run` is 1 it stays 1, with `status`=4, until reset. Strobes and pin changes do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External reset, synchronous, active high |
| cfg_map_ext | input | 1 | Pin: 1 maps external memory at address 0 |
| cfg_mem_type | input | 2 | Pin: external memory type, 01 = SDRAM |
| cfg_boot | input | 2 | Pin: boot process (00 direct, 01 ROM, 10 host, 11 direct) |
| sdram_init_done | input | 1 | SDRAM controller finished initialization (level) |
| dma_done | input | 1 | DMA engine finished the copy (pulse) |
| host_done | input | 1 | Host-written boot-complete strobe |
| dma_req | output | 1 | Single-cycle copy request |
| dma_src | output | SRC_W | Copy source address |
| dma_len | output | LEN_W | Copy length in words |
| cpu_run | output | 1 | 1 releases the CPU from internal reset |
| map_ext | output | 1 | Captured address-0 map select |
| status | output | 3 | 0 idle, 1 SDRAM wait, 2 copying, 3 host wait, 4 running |

## Verification
The properties assume the following about the inputs:

- `rst` is held for at least one clock edge before the block starts.
- The configuration pins are settled at the edge where reset is released.
- `dma_done` and `host_done` are single-cycle pulses that arrive only after the matching request or wait state is entered.

The stimulus drives every input on the falling edge. Each strobe is held for exactly one rising edge, and completion is never raised before the state that waits for it. Strobes that belong to the wrong flow are injected on purpose, and the pins are changed after capture, to show that the block ignores them.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SDRAM    = 3'd1,
    ST_COPY     = 3'd2,
    ST_HOST     = 3'd3,
    ST_RUN      = 3'd4,
    ST_HOST_ACK = 3'd5
  } boot_state_e;

  typedef struct packed {
    logic       map_ext;
    logic [1:0] mem_type;
    logic [1:0] boot;
  } boot_cfg_t;

  localparam logic [1:0] MEM_SDRAM = 2'b01;
  localparam logic [1:0] BOOT_ROM  = 2'b01;
  localparam logic [1:0] BOOT_HOST = 2'b10;

  localparam logic [2:0] STAT_IDLE  = 3'd0;
  localparam logic [2:0] STAT_SDRAM = 3'd1;
  localparam logic [2:0] STAT_COPY  = 3'd2;
  localparam logic [2:0] STAT_HOST  = 3'd3;
  localparam logic [2:0] STAT_RUN   = 3'd4;
endpackage

// File: rtl/boot_pin_latch.sv
module boot_pin_latch
  import boot_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      capture,
  input  boot_cfg_t pins,
  output boot_cfg_t cfg_q,
  output boot_cfg_t cfg_eff
);
  // Pins are stored only while the sequencer sits in idle after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (capture) begin
      cfg_q <= pins;
    end
  end

  // The decision at the capture edge must see the pins themselves.
  assign cfg_eff = capture ? pins : cfg_q;
endmodule

// File: rtl/boot_flow_fsm.sv
module boot_flow_fsm
  import boot_seq_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int LEN_W = 16,
  parameter logic [SRC_W-1:0] ROM_SRC = 32'h0040_0000,
  parameter logic [LEN_W-1:0] ROM_LEN = 16'd1024
) (
  input  logic             clk,
  input  logic             rst,
  input  boot_cfg_t        cfg,
  input  logic             sdram_init_done,
  input  logic             dma_done,
  input  logic             host_done,
  output logic             in_idle,
  output logic             dma_req,
  output logic [SRC_W-1:0] dma_src,
  output logic [LEN_W-1:0] dma_len,
  output logic             cpu_run,
  output logic [2:0]       status
);
  boot_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (cfg.boot == BOOT_ROM)       nxt = ST_COPY;
        else if (cfg.boot == BOOT_HOST) nxt = ST_HOST;
        else if (cfg.map_ext && cfg.mem_type == MEM_SDRAM) nxt = ST_SDRAM;
        else                            nxt = ST_RUN;
      end
      ST_SDRAM:    if (sdram_init_done) nxt = ST_RUN;
      ST_COPY:     if (dma_done)        nxt = ST_RUN;
      ST_HOST:     if (host_done)       nxt = ST_HOST_ACK;
      ST_HOST_ACK: nxt = ST_RUN;
      ST_RUN:      nxt = ST_RUN;
      default:     nxt = ST_IDLE;
    endcase
  end

  function automatic logic [2:0] stat_of(boot_state_e s);
    case (s)
      ST_SDRAM:              return STAT_SDRAM;
      ST_COPY:               return STAT_COPY;
      ST_HOST, ST_HOST_ACK:  return STAT_HOST;
      ST_RUN:                return STAT_RUN;
      default:               return STAT_IDLE;
    endcase
  endfunction

  logic issue;
  assign issue   = (state == ST_IDLE) && (nxt == ST_COPY);
  assign in_idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cpu_run <= 1'b0;
      status  <= STAT_IDLE;
      dma_req <= 1'b0;
      dma_src <= '0;
      dma_len <= '0;
    end else begin
      state   <= nxt;
      cpu_run <= (nxt == ST_RUN);
      status  <= stat_of(nxt);
      dma_req <= issue;
      if (issue) begin
        dma_src <= ROM_SRC;
        dma_len <= ROM_LEN;
      end
    end
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int LEN_W = 16,
  parameter logic [SRC_W-1:0] ROM_SRC = 32'h0040_0000,
  parameter logic [LEN_W-1:0] ROM_LEN = 16'd1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_map_ext,
  input  logic [1:0]       cfg_mem_type,
  input  logic [1:0]       cfg_boot,
  input  logic             sdram_init_done,
  input  logic             dma_done,
  input  logic             host_done,
  output logic             dma_req,
  output logic [SRC_W-1:0] dma_src,
  output logic [LEN_W-1:0] dma_len,
  output logic             cpu_run,
  output logic             map_ext,
  output logic [2:0]       status
);
  boot_cfg_t pins, cfg_q, cfg_eff;
  logic      in_idle;

  assign pins = '{map_ext: cfg_map_ext, mem_type: cfg_mem_type, boot: cfg_boot};

  boot_pin_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (in_idle),
    .pins    (pins),
    .cfg_q   (cfg_q),
    .cfg_eff (cfg_eff)
  );

  boot_flow_fsm #(
    .SRC_W   (SRC_W),
    .LEN_W   (LEN_W),
    .ROM_SRC (ROM_SRC),
    .ROM_LEN (ROM_LEN)
  ) u_fsm (
    .clk             (clk),
    .rst             (rst),
    .cfg             (cfg_eff),
    .sdram_init_done (sdram_init_done),
    .dma_done        (dma_done),
    .host_done       (host_done),
    .in_idle         (in_idle),
    .dma_req         (dma_req),
    .dma_src         (dma_src),
    .dma_len         (dma_len),
    .cpu_run         (cpu_run),
    .status          (status)
  );

  assign map_ext = cfg_q.map_ext;
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       sdram_init_done,
  input logic       dma_done,
  input logic       host_done,
  input logic       dma_req,
  input logic       cpu_run,
  input logic       map_ext,
  input logic [2:0] status
);
  // R1: reset clears the visible state one edge later
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!cpu_run && !dma_req && status == 3'd0));

  // R2: map select frozen once the flow has left idle
  a_r2_map_frozen: assert property (@(posedge clk) disable iff (rst)
    (status != 3'd0) |=> $stable(map_ext));

  // R4: held while SDRAM not ready
  a_r4_sdram_hold: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd1 && !sdram_init_done) |=> !cpu_run);

  // R5: copy request lasts one cycle and CPU held during copy
  a_r5_req_single: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);
  a_r5_copy_hold: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd2 && !dma_done) |=> !cpu_run);

  // R6: release exactly one cycle after the host strobe
  a_r6_host_delay: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd3 && !cpu_run && host_done) |=> (!cpu_run ##1 cpu_run));

  // R8: released CPU stays released and running
  a_r8_run_sticky: assert property (@(posedge clk) disable iff (rst)
    cpu_run |=> (cpu_run && status == 3'd4));
endmodule

bind boot_seq_top boot_seq_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .sdram_init_done (sdram_init_done),
  .dma_done        (dma_done),
  .host_done       (host_done),
  .dma_req         (dma_req),
  .cpu_run         (cpu_run),
  .map_ext         (map_ext),
  .status          (status)
);

// File: tb/boot_seq_top_bench.sv
`timescale 1ns/1ps
module boot_seq_top_bench;
  localparam logic [31:0] SRC = 32'h0040_0000;
  localparam logic [15:0] LEN = 16'd1024;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_map_ext = 0;
  logic [1:0]  cfg_mem_type = 0, cfg_boot = 0;
  logic        sdram_init_done = 0, dma_done = 0, host_done = 0;
  logic        dma_req, cpu_run, map_ext;
  logic [31:0] dma_src;
  logic [15:0] dma_len;
  logic [2:0]  status;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  boot_seq_top u_boot_seq_top (
    .clk(clk), .rst(rst), .cfg_map_ext(cfg_map_ext), .cfg_mem_type(cfg_mem_type),
    .cfg_boot(cfg_boot), .sdram_init_done(sdram_init_done), .dma_done(dma_done),
    .host_done(host_done), .dma_req(dma_req), .dma_src(dma_src), .dma_len(dma_len),
    .cpu_run(cpu_run), .map_ext(map_ext), .status(status)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Apply pins under reset, release, and return one falling edge after capture.
  task automatic boot(logic m, logic [1:0] t, logic [1:0] b);
    @(negedge clk);
    rst = 1; sdram_init_done = 0; dma_done = 0; host_done = 0;
    cfg_map_ext = m; cfg_mem_type = t; cfg_boot = b;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic pulse_dma();  dma_done = 1;  @(negedge clk); dma_done = 0;  endtask
  task automatic pulse_host(); host_done = 1; @(negedge clk); host_done = 0; endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; cfg_map_ext = 1; cfg_mem_type = 2'b01; cfg_boot = 2'b01;
    repeat (3) @(negedge clk);
    chk("R1", "cpu_run", cpu_run, 0);
    chk("R1", "status", status, 0);
    chk("R1", "dma_req", dma_req, 0);
    chk("R1", "map_ext", map_ext, 0);
  endtask

  task automatic t_direct();
    boot(0, 2'b01, 2'b00);
    chk("R3", "internal cpu_run", cpu_run, 1);
    chk("R3", "internal status", status, 4);
    chk("R3", "internal map", map_ext, 0);
    boot(1, 2'b00, 2'b00);
    chk("R3", "ext async cpu_run", cpu_run, 1);
    chk("R3", "ext async map", map_ext, 1);
  endtask

  task automatic t_sdram();
    boot(1, 2'b01, 2'b00);
    chk("R4", "wait status", status, 1);
    chk("R4", "held", cpu_run, 0);
    cfg_map_ext = 0; cfg_boot = 2'b10; cfg_mem_type = 2'b00;
    repeat (3) @(negedge clk);
    pulse_dma(); pulse_host();
    chk("R2", "map after pin change", map_ext, 1);
    chk("R2", "status after pin change", status, 1);
    chk("R4", "still held", cpu_run, 0);
    sdram_init_done = 1;
    @(negedge clk);
    chk("R4", "released", cpu_run, 1);
    chk("R4", "run status", status, 4);
  endtask

  task automatic t_rom();
    boot(0, 2'b00, 2'b01);
    chk("R5", "copy status", status, 2);
    chk("R5", "req", dma_req, 1);
    chk("R5", "src", dma_src, SRC);
    chk("R5", "len", {16'd0, dma_len}, {16'd0, LEN});
    @(negedge clk);
    chk("R5", "req single", dma_req, 0);
    pulse_host();
    chk("R5", "host ignored status", status, 2);
    chk("R5", "host ignored run", cpu_run, 0);
    pulse_dma();
    chk("R5", "released", cpu_run, 1);
    chk("R5", "run status", status, 4);
  endtask

  task automatic t_host();
    boot(1, 2'b01, 2'b10);
    chk("R6", "host status", status, 3);
    pulse_dma();
    chk("R6", "dma ignored", cpu_run, 0);
    chk("R6", "dma ignored status", status, 3);
    pulse_host();
    chk("R6", "held one more cycle", cpu_run, 0);
    chk("R6", "status during ack", status, 3);
    @(negedge clk);
    chk("R6", "released", cpu_run, 1);
    chk("R6", "run status", status, 4);
  endtask

  task automatic t_reserved();
    boot(1, 2'b01, 2'b11);
    chk("R7", "behaves direct sdram", status, 1);
    sdram_init_done = 1;
    @(negedge clk);
    chk("R7", "released", cpu_run, 1);
    boot(0, 2'b00, 2'b11);
    chk("R7", "direct internal", cpu_run, 1);
  endtask

  task automatic t_sticky();
    boot(0, 2'b00, 2'b00);
    cfg_map_ext = 1; cfg_boot = 2'b01;
    pulse_dma(); pulse_host();
    sdram_init_done = 1;
    repeat (2) @(negedge clk);
    chk("R8", "stays run", cpu_run, 1);
    chk("R8", "status run", status, 4);
    chk("R8", "no request", dma_req, 0);
    chk("R2", "map ignored", map_ext, 0);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_sdram();
    t_rom();
    t_host();
    t_reserved();
    t_sticky();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule